// File: doc/BRIEF.md
# PLL Coarse Lock Detector

This block decides whether a PLL is roughly on frequency. It counts the feedback clock's rising edges over a fixed span of reference clock cycles. From that count it sets or clears one active-high flag, which means the output frequency is within about ten percent of its target. The decision is taken once per refresh period of 32 reference cycles. The counting span is the first 14 cycles of each period, and the remaining cycles are idle.

The flag has hysteresis. An unlocked detector needs a count very close to the nominal 14 before it sets the flag. A locked detector tolerates a wider spread before it clears the flag again.

The feedback edges are counted in the feedback domain by a Gray-coded counter. That counter is passed into the reference domain through a two-flop synchroniser. All decision logic runs on the reference clock, so if the reference stops, the flag keeps its last value.

Top module: `coarse_lock_det`

## Requirements
- R1: While `rst_n` is low, `lock_o` is 0. After release it stays 0 until the first decision, which is taken at the 32nd rising edge of `ref_clk`.
- R2: `lock_o` changes only at reference rising edges whose index (counted from 1 after reset release) is a multiple of 32.
- R3: The decision at edge 32(p+1) uses the number of `fb_clk` rising edges that fall between reference edge 32p-1 and reference edge 32p+13. Edges that arrive outside this span have no effect on the decision.
- R4: When `lock_o` is 0, the decision sets it to 1 if the count is 13, 14 or 15. Otherwise it stays 0.
- R5: When `lock_o` is 1, the decision clears it to 0 if the count is 10 or less, or 18 or more. Otherwise it stays 1.
- R6: A count of 255 or more saturates at 255 and is treated as above the band, so it clears a set flag and never sets a clear one.
- R7: If `ref_clk` stops while `lock_o` is 1, `lock_o` stays 1, however many feedback edges arrive meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Divided reference clock; clocks all decision logic |
| fb_clk | input | 1 | Feedback clock whose rising edges are counted |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_o | output | 1 | Coarse-lock flag, active high |

## Verification
The feedback clock is built as a pulse train with a fixed number of edges per 14 reference cycles, so every counting span holds exactly the chosen count. The count is changed only in the idle part of each period.

Directed counts probe each band edge from both flag states: 12 against 13 and 15 against 16 when unlocked, 10 against 11 and 17 against 18 when locked. These show whether entry and exit use separate bands and whether each band is inclusive. A count of 300 shows that saturation is treated as too fast rather than wrapping into range. Random counts, including occasional very high ones, run the hysteresis sequence over many periods. A mid-run reset and a stopped reference with feedback still toggling show the reset value and the hold-on-loss rule.

// File: rtl/cld_pkg.sv
package cld_pkg;

  // Flag update rule: narrow band to set, wide band to keep.
  function automatic logic next_lock(input logic cur, input int unsigned n,
                                     input int unsigned set_lo, input int unsigned set_hi,
                                     input int unsigned keep_lo, input int unsigned keep_hi);
    if (!cur) return (n >= set_lo) && (n <= set_hi);
    return (n >= keep_lo) && (n <= keep_hi);
  endfunction

  // Saturating add used by the window accumulator.
  function automatic int unsigned sat_add(input int unsigned a, input int unsigned b,
                                          input int unsigned lim);
    int unsigned s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

endpackage

// File: rtl/cld_fb_counter.sv
module cld_fb_counter #(
  parameter int unsigned GW = 6
) (
  input  logic          fb_clk,
  input  logic          rst_n,
  output logic [GW-1:0] gray_o
);
  logic [GW-1:0] bin_q;
  logic [GW-1:0] bin_nxt;

  function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge fb_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_o <= to_gray(bin_nxt);
    end
  end
endmodule

// File: rtl/cld_gray_sync.sv
module cld_gray_sync #(
  parameter int unsigned GW = 6
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic [GW-1:0] gray_i,
  output logic [GW-1:0] bin_o
);
  logic [GW-1:0] s1_q;
  logic [GW-1:0] s2_q;

  function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = int'(GW) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  assign bin_o = from_gray(s2_q);
endmodule

// File: rtl/cld_phase.sv
module cld_phase #(
  parameter int unsigned PERIOD = 32,
  parameter int unsigned WINDOW = 14
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic acc_clr,
  output logic acc_en,
  output logic eval_stb
);
  localparam int unsigned PH_W = $clog2(PERIOD);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] PH_WEND = PH_W'(WINDOW);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)               ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                      ph_q <= ph_q + 1'b1;
  end

  assign acc_clr  = (ph_q == '0);
  assign acc_en   = (ph_q != '0) && (ph_q <= PH_WEND);
  assign eval_stb = (ph_q == PH_LAST);
endmodule

// File: rtl/coarse_lock_det.sv
module coarse_lock_det #(
  parameter int unsigned PERIOD  = 32,
  parameter int unsigned WINDOW  = 14,
  parameter int unsigned GRAY_W  = 6,
  parameter int unsigned ACC_W   = 8,
  parameter int unsigned SET_LO  = 13,
  parameter int unsigned SET_HI  = 15,
  parameter int unsigned KEEP_LO = 11,
  parameter int unsigned KEEP_HI = 17
) (
  input  logic ref_clk,
  input  logic fb_clk,
  input  logic rst_n,
  output logic lock_o
);
  import cld_pkg::*;

  localparam int unsigned ACC_MAX = (1 << ACC_W) - 1;

  logic [GRAY_W-1:0] fb_gray;
  logic [GRAY_W-1:0] sync_bin;
  logic [GRAY_W-1:0] prev_q;
  logic [GRAY_W-1:0] step;
  logic [ACC_W-1:0]  win_cnt;
  logic              acc_clr;
  logic              acc_en;
  logic              eval_stb;
  logic              lock_q;

  cld_fb_counter #(.GW(GRAY_W)) u_fbc (
    .fb_clk (fb_clk),
    .rst_n  (rst_n),
    .gray_o (fb_gray)
  );

  cld_gray_sync #(.GW(GRAY_W)) u_sync (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .gray_i  (fb_gray),
    .bin_o   (sync_bin)
  );

  cld_phase #(.PERIOD(PERIOD), .WINDOW(WINDOW)) u_phase (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .acc_clr  (acc_clr),
    .acc_en   (acc_en),
    .eval_stb (eval_stb)
  );

  // Feedback edges seen since the previous reference edge (modulo counter width).
  assign step = sync_bin - prev_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      win_cnt <= '0;
      lock_q  <= 1'b0;
    end else begin
      prev_q <= sync_bin;
      if (acc_clr)
        win_cnt <= '0;
      else if (acc_en)
        win_cnt <= ACC_W'(sat_add(32'(win_cnt), 32'(step), ACC_MAX));
      if (eval_stb)
        lock_q <= next_lock(lock_q, 32'(win_cnt), SET_LO, SET_HI, KEEP_LO, KEEP_HI);
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/cld_checker.sv
module cld_checker #(
  parameter int unsigned ACC_W   = 8,
  parameter int unsigned SET_LO  = 13,
  parameter int unsigned SET_HI  = 15,
  parameter int unsigned KEEP_LO = 11,
  parameter int unsigned KEEP_HI = 17
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic             lock_o,
  input logic             eval_stb,
  input logic             acc_en,
  input logic             acc_clr,
  input logic [ACC_W-1:0] win_cnt
);
  localparam logic [ACC_W-1:0] C_SLO = ACC_W'(SET_LO);
  localparam logic [ACC_W-1:0] C_SHI = ACC_W'(SET_HI);
  localparam logic [ACC_W-1:0] C_KLO = ACC_W'(KEEP_LO);
  localparam logic [ACC_W-1:0] C_KHI = ACC_W'(KEEP_HI);
  localparam logic [ACC_W-1:0] C_MAX = '1;

  a_r1_reset_low: assert property (@(posedge ref_clk) !rst_n |-> !lock_o);

  a_r2_only_at_eval: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(lock_o) |-> $past(eval_stb));

  a_r3_count_frozen: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!acc_en && !acc_clr) |=> $stable(win_cnt));

  a_r4_enter_band: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(win_cnt >= C_SLO && win_cnt <= C_SHI));

  a_r4_stay_open: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (eval_stb && !lock_o && (win_cnt < C_SLO || win_cnt > C_SHI)) |=> !lock_o);

  a_r5_exit_band: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(win_cnt < C_KLO || win_cnt > C_KHI));

  a_r5_stay_held: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (eval_stb && lock_o && win_cnt >= C_KLO && win_cnt <= C_KHI) |=> lock_o);

  a_r6_saturate: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_cnt == C_MAX && !acc_clr) |=> (win_cnt == C_MAX));
endmodule

bind coarse_lock_det cld_checker #(
  .ACC_W(ACC_W), .SET_LO(SET_LO), .SET_HI(SET_HI), .KEEP_LO(KEEP_LO), .KEEP_HI(KEEP_HI)
) u_chk (
  .ref_clk  (ref_clk),
  .rst_n    (rst_n),
  .lock_o   (lock_o),
  .eval_stb (eval_stb),
  .acc_en   (acc_en),
  .acc_clr  (acc_clr),
  .win_cnt  (win_cnt)
);

// File: tb/sim_coarse_lock_det.sv
`timescale 1ps/1ps
module sim_coarse_lock_det;
  logic ref_clk = 1'b0;
  logic fb_gen = 1'b0;
  logic fb_extra = 1'b0;
  logic fb_clk;
  logic rst_n = 1'b0;
  logic lock_o;
  bit   ref_run = 1'b1;
  bit   done = 1'b0;

  int c = 0;          // reference edge index since reset release
  int cur_n = 0;      // feedback edges per 14 reference cycles
  int checks = 0;
  int fails = 0;
  int r2_viol = 0;
  bit exp_lock = 1'b0;
  int prev_cnt = 0;
  logic mon_prev = 1'b0;

  assign fb_clk = fb_gen | fb_extra;

  coarse_lock_det u0 (
    .ref_clk (ref_clk),
    .fb_clk  (fb_clk),
    .rst_n   (rst_n),
    .lock_o  (lock_o)
  );

  // 200 MHz reference, can be stopped
  initial forever begin
    #2500;
    if (ref_run) ref_clk = ~ref_clk;
  end

  always @(posedge ref_clk or negedge rst_n)
    if (!rst_n) c <= 0;
    else        c <= c + 1;

  // Evenly spread feedback pulses: any 14 consecutive cycles carry exactly cur_n edges
  initial forever begin
    @(posedge ref_clk);
    if (rst_n) begin
      int k;
      #1;
      k = ((c + 1) * cur_n) / 14 - (c * cur_n) / 14;
      #399;
      for (int j = 0; j < k; j++) begin
        fb_gen = 1'b1; #100;
        fb_gen = 1'b0; #100;
      end
    end
  end

  // R2 monitor: the flag may move only in the cycle after an edge index that is a multiple of 32
  always @(negedge ref_clk) begin
    if (rst_n) begin
      if (lock_o !== mon_prev && (c % 32) != 0) r2_viol++;
      mon_prev = lock_o;
    end else mon_prev = 1'b0;
  end

  function automatic bit model_flag(bit cur, int n);
    if (cur) return !(n <= 10 || n >= 18);
    return n == 13 || n == 14 || n == 15;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic wait_cycle(int t);
    while (c < t) @(negedge ref_clk);
  endtask

  task automatic do_period(int p, int n);
    string tag;
    wait_cycle(32 * p - 12);
    cur_n = n;
    wait_cycle(32 * p + 4);
    tag = (prev_cnt == 255) ? "R6" : (exp_lock ? "R5" : "R4");
    exp_lock = model_flag(exp_lock, prev_cnt);
    check(lock_o === exp_lock, tag, int'(lock_o), int'(exp_lock));
    prev_cnt = (n > 255) ? 255 : n;
  endtask

  task automatic start_after_reset();
    cur_n = 0; prev_cnt = 0; exp_lock = 1'b0;
    #13000 rst_n = 1'b1;
    wait_cycle(20);
    check(lock_o === 1'b0, "R1", int'(lock_o), 0);
  endtask

  initial begin
    int dir[11] = '{12, 16, 13, 11, 17, 18, 15, 10, 14, 300, 14};
    int p;
    void'($urandom(32'd20240611));
    #10000;
    check(lock_o === 1'b0, "R1", int'(lock_o), 0);
    start_after_reset();
    p = 1;
    foreach (dir[i]) begin
      do_period(p, dir[i]); p++;
    end
    for (int i = 0; i < 24; i++) begin
      int r;
      int n;
      r = int'($urandom % 8);
      n = (r == 0) ? 200 + int'($urandom % 100) : 8 + int'($urandom % 13);
      do_period(p, n); p++;
    end
    do_period(p, 14); p++;
    do_period(p, 14); p++;
    do_period(p, 14); p++;
    check(lock_o === 1'b1, "R4", int'(lock_o), 1);
    // R1: asynchronous reset mid-period while locked
    wait_cycle(32 * (p - 1) + 10);
    #300 rst_n = 1'b0;
    #200 check(lock_o === 1'b0, "R1", int'(lock_o), 0);
    #14000;
    start_after_reset();
    do_period(1, 14);
    do_period(2, 14);
    do_period(3, 14);
    check(lock_o === 1'b1, "R4", int'(lock_o), 1);
    // R7: reference stops while locked, feedback keeps toggling
    wait_cycle(32 * 3 + 8);
    ref_run = 1'b0;
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 40; j++) begin
        fb_extra = 1'b1; #700;
        fb_extra = 1'b0; #700;
      end
      check(lock_o === 1'b1, "R7", int'(lock_o), 1);
    end
    check(r2_viol == 0, "R2", r2_viol, 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(64'd150000 * 64'd5000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule